// File: doc/BRIEF.md
# Memory Refresh Request Generator

This block paces refresh traffic for dynamic or pseudo-static memory. A programmable interval counter counts clock cycles. Each time it runs out, the block raises a request toward the bus arbiter and reloads the counter. The request stays up until the arbiter acknowledges it. The block then advances a 12-bit row counter, so successive refresh reads sweep every row in turn.

The address output is a complete 20-bit byte address for the refresh read. A programmable 7-bit base selects an 8 Kbyte-aligned region and fills the top bits. The row counter fills the bits below the base, and bit 0 is held low. Software sets the interval, the base and the enable through a small register-write port. The bus read itself is issued elsewhere.

Top module: `refresh_gen`

## Requirements
- R1: After reset, `req_o` is low and `addr_o` is zero. The interval, base, enable and row counter all start at zero.
- R2: With the block enabled and an interval N between 1 and 511 written, `req_o` rises on the Nth rising edge after the write edge. It expires again every N edges after that, and a new write restarts the count from N.
- R3: An interval value of zero raises no request, whatever the enable.
- R4: Once raised, `req_o` stays high until a cycle with `ack_i` high. Expiries that happen while a request is pending merge into it, so one acknowledge advances the row counter by exactly one.
- R5: `addr_o[19:13]` is the programmed base, `addr_o[12:1]` is the row counter and `addr_o[0]` is 0. The address is valid in every cycle, including the one in which `ack_i` is seen.
- R6: Each cycle with `req_o` and `ack_i` both high advances the row counter by one on that edge. The counter wraps from 0xFFF to 0x000.
- R7: `ack_i` has no effect while `req_o` is low: the row counter and `addr_o` are unchanged.
- R8: Writing enable = 0 clears `req_o` on that edge and freezes both the interval count and the row counter. A later enable resumes the interval from the frozen remainder.
- R9: Write port: when `wr_en_i` is high, `wr_sel_i` selects the target. Code 0 writes the interval from `wr_data_i[8:0]`, code 1 writes the base from `wr_data_i[6:0]`, and code 2 writes the enable from `wr_data_i[0]`. Code 3 is ignored. A write takes effect on the edge where it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 interval, 1 base, 2 enable |
| wr_data_i | input | 9 | Register write data |
| ack_i | input | 1 | Arbiter grant for the pending refresh |
| req_o | output | 1 | Refresh request, held until acknowledged |
| addr_o | output | 20 | Refresh read address |

## Verification
Directed patterns cover the corners:
- A short interval with a late acknowledge, which tells a merged expiry apart from a double count.
- A zero interval with `ack_i` held high, which shows that neither requests nor stray advances occur.
- A disable in the middle of a count, whose resume delay tells a frozen count apart from a reloaded one.
- An interval of one with a constant acknowledge, which drives the row counter through its wrap.

A random phase then mixes writes to all select codes with random acknowledge patterns. A cycle model derived from the requirements compares `req_o` and `addr_o` in every cycle. This catches ordering faults between a write, an expiry and an acknowledge that land on the same edge.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    SEL_INTERVAL = 2'd0,
    SEL_BASE     = 2'd1,
    SEL_CTRL     = 2'd2,
    SEL_NONE     = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/refresh_regs.sv
module refresh_regs
  import refresh_pkg::*;
#(
  parameter int IV_W   = 9,
  parameter int BASE_W = 7,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [IV_W-1:0]   interval_o,
  output logic [BASE_W-1:0] base_o,
  output logic              enable_o,
  output logic              enable_next_o,
  output logic              iv_load_o,
  output logic [IV_W-1:0]   iv_load_val_o
);
  reg_sel_e sel;
  logic     wr_iv, wr_base, wr_ctrl;

  assign sel     = reg_sel_e'(wr_sel_i);
  assign wr_iv   = wr_en_i && (sel == SEL_INTERVAL);
  assign wr_base = wr_en_i && (sel == SEL_BASE);
  assign wr_ctrl = wr_en_i && (sel == SEL_CTRL);

  assign iv_load_o     = wr_iv;
  assign iv_load_val_o = wr_data_i[IV_W-1:0];
  assign enable_next_o = wr_ctrl ? wr_data_i[0] : enable_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      interval_o <= '0;
      base_o     <= '0;
      enable_o   <= 1'b0;
    end else begin
      if (wr_iv)   interval_o <= wr_data_i[IV_W-1:0];
      if (wr_base) base_o     <= wr_data_i[BASE_W-1:0];
      enable_o <= enable_next_o;
    end
  end

  p_base_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_base |=> base_o == $past(wr_data_i[BASE_W-1:0]));
  p_base_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_base |=> $stable(base_o));
endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer #(
  parameter int IV_W = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic [IV_W-1:0] interval_i,
  input  logic            load_i,
  input  logic [IV_W-1:0] load_val_i,
  output logic            expire_o
);
  logic [IV_W-1:0] cnt_q;
  logic            run;

  assign run      = enable_i && (interval_i != '0);
  // a write to the interval restarts the count and masks this cycle's expiry
  assign expire_o = run && !load_i && (cnt_q <= IV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (run) begin
      if (cnt_q <= IV_W'(1))      cnt_q <= interval_i;
      else                        cnt_q <= cnt_q - IV_W'(1);
    end
  end

  p_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_q == $past(interval_i));
  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !load_i) |=> $stable(cnt_q));
  p_zero_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interval_i == '0) |-> !expire_o);
endmodule

// File: rtl/refresh_row.sv
module refresh_row #(
  parameter int ROW_W  = 12,
  parameter int BASE_W = 7,
  parameter int ADDR_W = BASE_W + ROW_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        row_q <= '0;
    else if (advance_i) row_q <= row_q + ROW_W'(1);
  end

  assign addr_o = {base_i, row_q, 1'b0};

  p_row_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i |=> row_q == $past(row_q) + ROW_W'(1));
  p_row_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i |=> $stable(row_q));
endmodule

// File: rtl/refresh_gen.sv
module refresh_gen #(
  parameter  int IV_W   = 9,
  parameter  int ROW_W  = 12,
  parameter  int BASE_W = 7,
  localparam int DATA_W = (IV_W > BASE_W) ? IV_W : BASE_W,
  localparam int ADDR_W = BASE_W + ROW_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [IV_W-1:0]   interval;
  logic [BASE_W-1:0] base;
  logic              enable, enable_next, iv_load, expire, req_q, advance;
  logic [IV_W-1:0]   iv_load_val;

  refresh_regs #(.IV_W(IV_W), .BASE_W(BASE_W), .DATA_W(DATA_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .interval_o(interval), .base_o(base), .enable_o(enable),
    .enable_next_o(enable_next), .iv_load_o(iv_load), .iv_load_val_o(iv_load_val)
  );

  refresh_pacer #(.IV_W(IV_W)) i_pacer (
    .clk_i, .rst_ni, .enable_i(enable), .interval_i(interval),
    .load_i(iv_load), .load_val_i(iv_load_val), .expire_o(expire)
  );

  assign advance = req_q && ack_i;

  refresh_row #(.ROW_W(ROW_W), .BASE_W(BASE_W), .ADDR_W(ADDR_W)) i_row (
    .clk_i, .rst_ni, .advance_i(advance), .base_i(base), .addr_o
  );

  // expiries during a pending request merge into it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= enable_next && (expire || (req_q && !ack_i));
  end

  assign req_o = req_q;

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && enable_next) |=> req_o);
  p_off_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable |-> !req_o);
  p_rise_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(expire));
  p_a0_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o[0] == 1'b0);
endmodule

// File: tb/test_refresh_gen.sv
module test_refresh_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [8:0]  wr_data = '0;
  logic        ack = 1'b0;
  logic        req;
  logic [19:0] addr;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  bit         m_en, m_req;
  logic [8:0] m_iv, m_cnt;
  logic [6:0] m_base;
  logic [11:0] m_row;

  always #10 clk = ~clk;

  refresh_gen i_refresh_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .ack_i(ack), .req_o(req), .addr_o(addr)
  );

  function automatic logic [19:0] exp_addr(logic [6:0] b, logic [11:0] r);
    return {b, r, 1'b0};
  endfunction

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic model_edge();
    bit wiv, wbase, wctl, ex, nen;
    wiv   = wr_en && wr_sel == 2'd0;
    wbase = wr_en && wr_sel == 2'd1;
    wctl  = wr_en && wr_sel == 2'd2;
    ex    = m_en && m_iv != 0 && m_cnt <= 1 && !wiv;
    nen   = wctl ? wr_data[0] : m_en;
    if (m_req && ack) m_row = m_row + 12'd1;
    m_req = nen && (ex || (m_req && !ack));
    if (wiv) m_cnt = wr_data;
    else if (m_en && m_iv != 0) m_cnt = (m_cnt <= 1) ? m_iv : m_cnt - 9'd1;
    if (wiv) m_iv = wr_data;
    if (wbase) m_base = wr_data[6:0];
    m_en = nen;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({tag, " req"}, req, m_req);
    check({tag, " addr"}, addr, exp_addr(m_base, m_row));
  endtask

  task automatic wr(logic [1:0] s, logic [8:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int r0, wait_n;
    void'($urandom(32'd4242));
    m_en = 0; m_req = 0; m_iv = 0; m_cnt = 0; m_base = 0; m_row = 0;
    #15;
    check("R1 req", req, 0);
    check("R1 addr", addr, 0);
    @(negedge clk); rst_n = 1'b1;
    tick();

    tag = "R5";
    wr(2'd1, 9'h055);
    check("R5 R9 base", addr, 20'hAA000);

    tag = "R2";
    wr(2'd0, 9'd5);
    wr(2'd2, 9'd1);
    for (int i = 0; i < 4; i++) begin tick(); check("R2 early", req, 0); end
    tick(); check("R2 rise", req, 1);

    tag = "R4";
    for (int i = 0; i < 12; i++) begin tick(); check("R4 hold", req, 1); end
    ack = 1'b1;
    check("R5 addr at ack", addr, 20'hAA000);
    tick(); ack = 1'b0;
    check("R4 one step", addr, 20'hAA002);

    tag = "R3";
    wr(2'd0, 9'd0);
    ack = 1'b1; tick(); ack = 1'b0;
    r0 = addr;
    ack = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick();
      check("R3 quiet", req, 0);
      check("R7 ack ignored", addr, r0);
    end
    ack = 1'b0;

    tag = "R8";
    wr(2'd0, 9'd10);
    for (int i = 0; i < 4; i++) tick();
    wr(2'd2, 9'd0);
    r0 = addr;
    for (int i = 0; i < 20; i++) begin
      tick(); check("R8 frozen req", req, 0); check("R8 frozen row", addr, r0);
    end
    wr(2'd2, 9'd1);
    for (int i = 0; i < 4; i++) begin tick(); check("R8 resume early", req, 0); end
    tick(); check("R8 resume remainder", req, 1);
    wr(2'd2, 9'd0);
    check("R8 drop", req, 0);

    tag = "R6";
    wr(2'd0, 9'd1);
    wr(2'd2, 9'd1);
    r0 = addr;
    ack = 1'b1;
    wait_n = 0;
    while (wait_n < 4096) begin
      if (req) wait_n++;
      tick();
    end
    ack = 1'b0;
    tick();
    check("R6 wrap", addr, r0);

    tag = "R9 random";
    for (int i = 0; i < 3000; i++) begin
      ack = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 19) == 0) begin
        logic [1:0] s;
        logic [8:0] d;
        s = 2'($urandom_range(0, 3));
        d = 9'($urandom_range(0, 511));
        if (s == 2'd0) d = 9'($urandom_range(0, 12));
        if (s == 2'd2) d = 9'($urandom_range(0, 4) != 0);
        wr(s, d);
      end else tick();
    end
    ack = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule